// File: doc/BRIEF.md
# System Bus Clock-Enable Divider

This block turns a single system clock into a family of single-cycle enable strobes that pace the main system bus, two peripheral buses, two timer groups and a system-tick counter. No divided clocks are produced: every output is a one-cycle pulse in the system clock domain. Downstream logic stays on the system clock and advances only on the cycles its strobe is high.

A 4-bit field picks the system bus divider. Two 3-bit fields pick the dividers of the two peripheral buses, and each of these further divides the system bus rate. Each timer group runs at its peripheral bus rate when that divider is 1, and at twice that rate otherwise. A new setting is taken up only at the end of the current system bus period, so a period in progress always finishes at its old length. A combinational flag reports when the active setting would push the system bus or either peripheral bus above its allowed frequency, given the system clock frequency set as a parameter.

Top module: `bus_clk_en_gen`

## Requirements
- R1: `hclk_en` pulses once every D system clock cycles. D is 1 for `hdiv_sel` codes 0 to 7, and 2, 4, 8, 16, 64, 128, 256, 512 for codes 8 to 15 in that order.
- R2: `pclk1_en` pulses once every D x P1 cycles and `pclk2_en` once every D x P2 cycles. P is 1 for codes 0 to 3 of the matching 3-bit select, and 2, 4, 8, 16 for codes 4 to 7. The two selects act independently.
- R3: `tmr1_en` and `tmr2_en` pulse once every D cycles when their bus divider P is 1, and once every D x P/2 cycles otherwise.
- R4: `tick_en` pulses once every 8 x D cycles.
- R5: Every peripheral, timer and tick strobe falls on a cycle in which `hclk_en` is also high.
- R6: A select change is applied at the end of the running system bus period. The `hclk_en` pulse that closes that period keeps the old spacing, and the spacing after it follows the new setting.
- R7: `rate_err` is high exactly when SYS_CLK_HZ / D exceeds AHB_MAX_HZ, or SYS_CLK_HZ / (D x P) exceeds APB_MAX_HZ for either peripheral bus. It is evaluated from the active (applied) setting.
- R8: After reset the active setting divides everything by 1, so `hclk_en`, `pclk1_en`, `pclk2_en`, `tmr1_en` and `tmr2_en` are high in every cycle from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdiv_sel | input | 4 | System bus divider code |
| pdiv1_sel | input | 3 | First peripheral bus divider code |
| pdiv2_sel | input | 3 | Second peripheral bus divider code |
| hclk_en | output | 1 | System bus enable strobe |
| pclk1_en | output | 1 | First peripheral bus enable strobe |
| pclk2_en | output | 1 | Second peripheral bus enable strobe |
| tmr1_en | output | 1 | Timer enable derived from the first peripheral bus |
| tmr2_en | output | 1 | Timer enable derived from the second peripheral bus |
| tick_en | output | 1 | System-tick enable, system bus rate divided by 8 |
| rate_err | output | 1 | Active setting exceeds a bus frequency limit |

## Verification
The critical overlap is a select change written in the final cycle of a system bus period, so that the setting is taken up on the same edge that launches the closing `hclk_en` pulse. The bench writes a new code exactly three cycles after a divide-by-4 pulse. It then requires the next pulse one cycle later at the old spacing and the one after at the new divide-by-8 spacing. A second case drops from divide-by-512 to divide-by-1 in mid-period. There the old period must still run its full length before strobes appear every cycle. Sweeps over all system bus codes and all peripheral code pairs check each strobe's spacing, phase and the limit flag.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int HSEL_W   = 4;
    localparam int PSEL_W   = 3;
    localparam int H_SH_MAX = 9;
    localparam int P_SH_MAX = 4;
    localparam int H_SH_W   = $clog2(H_SH_MAX + 1);
    localparam int P_SH_W   = $clog2(P_SH_MAX + 1);
    localparam int HCNT_W   = H_SH_MAX;
    localparam int SLOT_W   = P_SH_MAX;

    typedef struct packed {
        logic [H_SH_W-1:0] h_sh;
        logic [P_SH_W-1:0] p1_sh;
        logic [P_SH_W-1:0] p2_sh;
    } div_cfg_t;

    function automatic logic [H_SH_W-1:0] hsel_to_shift(input logic [HSEL_W-1:0] code);
        logic [H_SH_W-1:0] sh;
        if (!code[HSEL_W-1]) begin
            sh = '0;
        end else begin
            case (code[2:0])
                3'd0:    sh = H_SH_W'(1);
                3'd1:    sh = H_SH_W'(2);
                3'd2:    sh = H_SH_W'(3);
                3'd3:    sh = H_SH_W'(4);
                3'd4:    sh = H_SH_W'(6);
                3'd5:    sh = H_SH_W'(7);
                3'd6:    sh = H_SH_W'(8);
                default: sh = H_SH_W'(9);
            endcase
        end
        return sh;
    endfunction

    function automatic logic [P_SH_W-1:0] psel_to_shift(input logic [PSEL_W-1:0] code);
        logic [P_SH_W-1:0] sh;
        if (!code[PSEL_W-1]) sh = '0;
        else                 sh = P_SH_W'(code[1:0]) + P_SH_W'(1);
        return sh;
    endfunction

endpackage

// File: rtl/bcg_hdiv.sv
module bcg_hdiv
    import bcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HSEL_W-1:0] hdiv_sel,
    input  logic [PSEL_W-1:0] pdiv1_sel,
    input  logic [PSEL_W-1:0] pdiv2_sel,
    output div_cfg_t          cfg,
    output logic              hclk_en
);

    typedef struct packed {
        logic [HCNT_W-1:0] cnt;
        div_cfg_t          cfg;
    } hdiv_st_t;

    hdiv_st_t          st_d, st_q;
    logic [HCNT_W-1:0] last_cnt;
    logic              period_end;

    always_comb begin
        last_cnt   = HCNT_W'((32'd1 << st_q.cfg.h_sh) - 32'd1);
        period_end = (st_q.cnt == last_cnt);
        st_d       = st_q;
        if (period_end) begin
            st_d.cnt       = '0;
            st_d.cfg.h_sh  = hsel_to_shift(hdiv_sel);
            st_d.cfg.p1_sh = psel_to_shift(pdiv1_sel);
            st_d.cfg.p2_sh = psel_to_shift(pdiv2_sel);
        end else begin
            st_d.cnt = st_q.cnt + HCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg     = st_q.cfg;
    assign hclk_en = (st_q.cnt == '0);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_cnt); // R1
    AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(period_end) |-> $stable(st_q.cfg)); // R6
    AST_STROBE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $past(period_end) |-> hclk_en); // R6

endmodule

// File: rtl/bcg_slot.sv
module bcg_slot
    import bcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hclk_en,
    output logic [SLOT_W-1:0] slot
);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hclk_en) st_d.slot = st_q.slot + SLOT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot = st_q.slot;

    AST_SLOT_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !hclk_en |=> $stable(slot)); // R2

endmodule

// File: rtl/bcg_tap.sv
module bcg_tap
    import bcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hclk_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [P_SH_W-1:0] p_sh,
    output logic              pclk_en,
    output logic              tmr_en
);

    logic [P_SH_W-1:0] t_sh;
    logic [SLOT_W-1:0] p_mask;
    logic [SLOT_W-1:0] t_mask;

    always_comb begin
        t_sh    = (p_sh == '0) ? '0 : p_sh - P_SH_W'(1);
        p_mask  = SLOT_W'((32'd1 << p_sh) - 32'd1);
        t_mask  = SLOT_W'((32'd1 << t_sh) - 32'd1);
        pclk_en = hclk_en && ((slot & p_mask) == '0);
        tmr_en  = hclk_en && ((slot & t_mask) == '0);
    end

    AST_TMR_COVERS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        pclk_en |-> tmr_en); // R3

endmodule

// File: rtl/bus_clk_en_gen.sv
module bus_clk_en_gen
    import bcg_pkg::*;
#(
    parameter longint unsigned SYS_CLK_HZ = 64'd108_000_000,
    parameter longint unsigned AHB_MAX_HZ = 64'd108_000_000,
    parameter longint unsigned APB_MAX_HZ = 64'd54_000_000,
    parameter int              TICK_SH    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] hdiv_sel,
    input  logic [2:0] pdiv1_sel,
    input  logic [2:0] pdiv2_sel,
    output logic       hclk_en,
    output logic       pclk1_en,
    output logic       pclk2_en,
    output logic       tmr1_en,
    output logic       tmr2_en,
    output logic       tick_en,
    output logic       rate_err
);

    localparam int NUM_PBUS = 2;

    div_cfg_t          cfg;
    logic [SLOT_W-1:0] slot;
    logic [P_SH_W-1:0] p_sh_v   [NUM_PBUS];
    logic              pclk_v   [NUM_PBUS];
    logic              tmr_v    [NUM_PBUS];

    bcg_hdiv i_hdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdiv_sel  (hdiv_sel),
        .pdiv1_sel (pdiv1_sel),
        .pdiv2_sel (pdiv2_sel),
        .cfg       (cfg),
        .hclk_en   (hclk_en)
    );

    bcg_slot i_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .hclk_en (hclk_en),
        .slot    (slot)
    );

    assign p_sh_v[0] = cfg.p1_sh;
    assign p_sh_v[1] = cfg.p2_sh;

    for (genvar g = 0; g < NUM_PBUS; g++) begin : g_pbus
        bcg_tap i_tap (
            .clk     (clk),
            .rst_n   (rst_n),
            .hclk_en (hclk_en),
            .slot    (slot),
            .p_sh    (p_sh_v[g]),
            .pclk_en (pclk_v[g]),
            .tmr_en  (tmr_v[g])
        );
    end

    assign pclk1_en = pclk_v[0];
    assign pclk2_en = pclk_v[1];
    assign tmr1_en  = tmr_v[0];
    assign tmr2_en  = tmr_v[1];
    assign tick_en  = hclk_en && (slot[TICK_SH-1:0] == '0);

    function automatic logic over_limit(input div_cfg_t c);
        longint unsigned h_lim;
        longint unsigned p1_lim;
        longint unsigned p2_lim;
        h_lim  = AHB_MAX_HZ << c.h_sh;
        p1_lim = APB_MAX_HZ << (c.h_sh + c.p1_sh);
        p2_lim = APB_MAX_HZ << (c.h_sh + c.p2_sh);
        return (SYS_CLK_HZ > h_lim) || (SYS_CLK_HZ > p1_lim) || (SYS_CLK_HZ > p2_lim);
    endfunction

    assign rate_err = over_limit(cfg);

    AST_DERIVED_IN_AHB: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk1_en || pclk2_en || tmr1_en || tmr2_en || tick_en) |-> hclk_en); // R5
    AST_TICK_ON_PBUS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (int'(cfg.p1_sh) <= TICK_SH)) |-> pclk1_en); // R4

endmodule

// File: tb/test_bus_clk_en_gen.sv
module test_bus_clk_en_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hdiv_sel = '0;
    logic [2:0] pdiv1_sel = '0;
    logic [2:0] pdiv2_sel = '0;
    logic       hclk_en, pclk1_en, pclk2_en, tmr1_en, tmr2_en, tick_en, rate_err;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_clk_en_gen i_bus_clk_en_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdiv_sel  (hdiv_sel),
        .pdiv1_sel (pdiv1_sel),
        .pdiv2_sel (pdiv2_sel),
        .hclk_en   (hclk_en),
        .pclk1_en  (pclk1_en),
        .pclk2_en  (pclk2_en),
        .tmr1_en   (tmr1_en),
        .tmr2_en   (tmr2_en),
        .tick_en   (tick_en),
        .rate_err  (rate_err)
    );

    // strobe monitor: spacing of the most recent two pulses of each output
    logic [5:0] en_vec;
    assign en_vec = {tick_en, tmr2_en, tmr1_en, pclk2_en, pclk1_en, hclk_en};

    longint cyc = 0;
    int     epoch = 0;
    int     mon_epoch = 0;
    longint last_t [6];
    longint gap    [6];
    int     npulse [6];
    int     bad_phase = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (epoch != mon_epoch) begin
            mon_epoch = epoch;
            bad_phase = 0;
            for (int i = 0; i < 6; i++) begin
                npulse[i] = 0;
                gap[i]    = 0;
            end
        end
        if (rst_n) begin
            if ((|en_vec[5:1]) && !en_vec[0]) bad_phase = bad_phase + 1;
            for (int i = 0; i < 6; i++) begin
                if (en_vec[i]) begin
                    if (npulse[i] > 0) gap[i] = cyc - last_t[i];
                    last_t[i] = cyc;
                    npulse[i] = npulse[i] + 1;
                end
            end
        end
    end

    function automatic longint hdiv_of(input int code);
        case (code)
            8:       return 2;
            9:       return 4;
            10:      return 8;
            11:      return 16;
            12:      return 64;
            13:      return 128;
            14:      return 256;
            15:      return 512;
            default: return 1;
        endcase
    endfunction

    function automatic longint pdiv_of(input int code);
        if (code < 4) return 1;
        return longint'(1) << (code - 3);
    endfunction

    function automatic longint tdiv_of(input longint p);
        return (p == 1) ? 1 : p / 2;
    endfunction

    function automatic bit limit_exp(input longint d, input longint p1, input longint p2);
        longint sys;
        sys = 108_000_000;
        return (sys > 108_000_000 * d) || (sys > 54_000_000 * d * p1) || (sys > 54_000_000 * d * p2);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nerr = nerr + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    longint cur_d = 1;

    task automatic run_cfg(input int hc, input int p1c, input int p2c);
        longint d, p1, p2;
        d  = hdiv_of(hc);
        p1 = pdiv_of(p1c);
        p2 = pdiv_of(p2c);
        @(negedge clk);
        hdiv_sel  = 4'(hc);
        pdiv1_sel = 3'(p1c);
        pdiv2_sel = 3'(p2c);
        repeat (int'(cur_d) + 2) @(negedge clk);
        cur_d = d;
        epoch = epoch + 1;
        repeat (int'(32 * d + 4)) @(negedge clk);
        check("R1 hclk_en spacing", gap[0], d);
        check("R2 pclk1_en spacing", gap[1], d * p1);
        check("R2 pclk2_en spacing", gap[2], d * p2);
        check("R3 tmr1_en spacing", gap[3], d * tdiv_of(p1));
        check("R3 tmr2_en spacing", gap[4], d * tdiv_of(p2));
        check("R4 tick_en spacing", gap[5], d * 8);
        check("R5 strobes outside hclk_en", bad_phase, 0);
        check("R7 rate_err", rate_err, limit_exp(d, p1, p2));
    endtask

    task automatic wait_hclk(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!hclk_en);
    endtask

    initial begin
        int g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: everything divides by 1 straight after reset
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 hclk_en after reset", hclk_en, 1);
            check("R8 pclk1_en after reset", pclk1_en, 1);
            check("R8 pclk2_en after reset", pclk2_en, 1);
            check("R8 tmr1_en after reset", tmr1_en, 1);
            check("R8 tmr2_en after reset", tmr2_en, 1);
        end
        check("R7 rate_err after reset", rate_err, 1);

        // R2 R3 R7: all peripheral code pairs at system bus divide-by-1
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                run_cfg(0, a, b);

        // R1 R4: every system bus code
        for (int h = 0; h < 16; h++)
            run_cfg(h, 5, 7);
        run_cfg(9, 4, 0);

        // R6: drop from 512 to 1 in mid-period
        run_cfg(15, 7, 7);
        wait_hclk(g);
        repeat (100) @(negedge clk);
        hdiv_sel = 4'd0;
        wait_hclk(g);
        check("R6 old period completes", 100 + g, 512);
        wait_hclk(g);
        check("R6 new spacing after change", g, 1);

        // R6: change written in the last cycle of a divide-by-4 period
        hdiv_sel = 4'd9;
        repeat (4) @(negedge clk);
        wait_hclk(g);
        repeat (3) @(negedge clk);
        hdiv_sel = 4'd10;
        wait_hclk(g);
        check("R6 closing pulse keeps old spacing", 3 + g, 4);
        wait_hclk(g);
        check("R6 next spacing follows new code", g, 8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            nchk = nchk + 1;
            nerr = nerr + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule